// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block controls one 32-pin general-purpose I/O port. Software drives output values and output enables per pin, reads back the synchronized pin levels, and sets up interrupt detection per pin. Each pin can watch for a rising edge, a falling edge, a high level or a low level. Detected events latch into a status register. The status bits whose enable is set are ORed into a single registered interrupt line.

Software reaches the registers over a simple single-cycle bus. Address bits [10:8] select one of eight registers. Address bits [3:2] select how a write is applied: a plain write, a write that only sets bits, or a write that only clears bits. A read at any of these addresses returns the register value in the cycle after the request. A status bit can be acknowledged only through the clear-only address.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads as zero, `pin_oe` is all zero and `irq` is low.
- R2: The register index is `bus_addr[10:8]`: 0 output data, 1 input data, 2 output enable, 3 interrupt route, 4 interrupt enable, 5 level select, 6 polarity, 7 status. A read (`bus_sel`=1, `bus_wr`=0) puts the register value on `bus_rdata` after the next clock edge, whatever `bus_addr[3:2]` is, and `bus_rdata` holds that value until the next read.
- R3: For a write, `bus_addr[3:2]` selects the write action: 0 loads the data word, 1 sets the bits written as 1, 2 clears the bits written as 1, and 3 leaves the register unchanged.
- R4: `pin_out` always equals the output-data register and `pin_oe` always equals the output-enable register, where 1 means the pin is driven.
- R5: The input-data register shows `pin_in` after a two-flop synchronizer. A write to the input-data register has no effect.
- R6: The mode of pin p is the code {polarity[p], level[p]}: 0 falling edge, 1 low level, 2 rising edge, 3 high level. An edge is detected by comparing the synchronized level with its value from the previous cycle.
- R7: A pin sets its status bit only when both its route bit and its enable bit are 1. Clearing the enable bit masks the interrupt but leaves the status bit as it is.
- R8: A status bit is cleared only by writing 1 to that bit position with write action 2. Write actions 0, 1 and 3 on the status register have no effect.
- R9: In edge mode a status bit stays set until it is cleared. In level mode the status bit is set again on every cycle the active level is present. When a detection and a clear hit the same bit in the same cycle, the detection wins.
- R10: `irq` is registered. It is high in the cycle after (status AND enable) is non-zero, and low in the cycle after that AND is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request valid for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Register index in [10:8], write action in [3:2] |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output level for each pin |
| pin_oe | output | 32 | Output enable for each pin |
| irq | output | 1 | Port interrupt, registered |

## Verification
The hardest case to reach from the ports is a level-mode pin whose clear write arrives while its active level is still present, so that the detection and the acknowledge land on the same status bit in the same cycle. The stimulus holds a pin at its active level, issues a clear-only write to the status register, and reads the status back to confirm the bit is set again. It then releases the level, clears once more, and confirms the bit stays low. A behavioural model running in parallel checks the outputs on every clock through the same collisions and through the masked-enable and unrouted-pin cases.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned ACT_W = 2;
  localparam int unsigned IDX_LSB = 8;
  localparam int unsigned ACT_LSB = 2;
  localparam int unsigned NREG = 1 << IDX_W;

  typedef logic [IDX_W-1:0] reg_idx_t;
  typedef logic [ACT_W-1:0] wr_act_t;

  // register indices; order is fixed by the address decode
  localparam reg_idx_t RG_DOUT  = 3'd0;
  localparam reg_idx_t RG_DIN   = 3'd1;
  localparam reg_idx_t RG_OE    = 3'd2;
  localparam reg_idx_t RG_ROUTE = 3'd3;
  localparam reg_idx_t RG_IEN   = 3'd4;
  localparam reg_idx_t RG_LVL   = 3'd5;
  localparam reg_idx_t RG_POL   = 3'd6;
  localparam reg_idx_t RG_STAT  = 3'd7;

  // write actions
  localparam wr_act_t ACT_LOAD = 2'd0;
  localparam wr_act_t ACT_SET  = 2'd1;
  localparam wr_act_t ACT_CLR  = 2'd2;
  localparam wr_act_t ACT_NOP  = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;
  logic [W-1:0] delayed;
  logic [1:0]   warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1  <= '0;
      stage2  <= '0;
      delayed <= '0;
      warm    <= '0;
    end else begin
      stage1  <= d_i;
      stage2  <= stage1;
      delayed <= stage2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign sync_o = stage2;
  assign prev_o = delayed;

  // R5
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2) |-> (sync_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] route_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] ev_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic active;
    logic changed;
    logic hit;
    // active level after polarity: high/rising when pol=1
    assign active  = pol_i[p] ? cur_i[p] : ~cur_i[p];
    assign changed = cur_i[p] ^ prev_i[p];
    assign hit     = lvl_i[p] ? active : (active & changed);
    assign ev_o[p] = hit & route_i[p] & ien_i[p];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  din_i,
  input  logic [W-1:0]  ev_i,
  output logic [W-1:0]  dout_o,
  output logic [W-1:0]  oe_o,
  output logic [W-1:0]  route_o,
  output logic [W-1:0]  ien_o,
  output logic [W-1:0]  lvl_o,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  stat_o
);
  reg_idx_t     idx;
  wr_act_t      act;
  logic         wr_hit;
  logic         rd_hit;
  logic [W-1:0] view [NREG];
  logic         unused_addr;

  assign idx    = bus_addr[IDX_LSB +: IDX_W];
  assign act    = bus_addr[ACT_LSB +: ACT_W];
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;
  assign unused_addr = ^bus_addr;

  function automatic logic [W-1:0] apply_act(input logic [W-1:0] old,
                                             input logic [W-1:0] wd,
                                             input wr_act_t a);
    case (a)
      ACT_LOAD: apply_act = wd;
      ACT_SET:  apply_act = old | wd;
      ACT_CLR:  apply_act = old & ~wd;
      default:  apply_act = old;
    endcase
  endfunction

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == int'(RG_DIN)) begin : g_in
      assign view[k] = din_i;
    end else if (k == int'(RG_STAT)) begin : g_stat
      logic [W-1:0] q;
      logic [W-1:0] ack;
      assign ack = (wr_hit && idx == RG_STAT && act == ACT_CLR) ? bus_wdata : '0;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~ack) | ev_i;
      end
      assign view[k] = q;
    end else begin : g_cfg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (wr_hit && idx == reg_idx_t'(k)) q <= apply_act(q, bus_wdata, act);
      end
      assign view[k] = q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= view[idx];
  end

  assign dout_o  = view[RG_DOUT];
  assign oe_o    = view[RG_OE];
  assign route_o = view[RG_ROUTE];
  assign ien_o   = view[RG_IEN];
  assign lvl_o   = view[RG_LVL];
  assign pol_o   = view[RG_POL];
  assign stat_o  = view[RG_STAT];

  // R3
  oe_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && idx == RG_OE && act == ACT_LOAD) |=> (oe_o == $past(bus_wdata)));
  // R3
  oe_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && idx == RG_OE && act == ACT_NOP) |=> $stable(oe_o));
  // R8
  stat_no_plain_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && idx == RG_STAT && act != ACT_CLR && ev_i == '0) |=> $stable(stat_o));
  // R8
  stat_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && idx == RG_STAT && act == ACT_CLR)
      |=> ((stat_o & $past(bus_wdata) & ~$past(ev_i)) == '0));
  // R9
  stat_set_source_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_o & ~$past(stat_o) & ~$past(ev_i)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned NPIN = 32,
  parameter int unsigned AW   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  logic [NPIN-1:0] sync_lvl, prev_lvl, ev;
  logic [NPIN-1:0] route, ien, lvl, pol, stat;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_in), .sync_o(sync_lvl), .prev_o(prev_lvl)
  );

  gpio_detect #(.W(NPIN)) u_detect (
    .cur_i(sync_lvl), .prev_i(prev_lvl), .route_i(route), .ien_i(ien),
    .lvl_i(lvl), .pol_i(pol), .ev_o(ev)
  );

  gpio_irq_bank #(.W(NPIN), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din_i(sync_lvl), .ev_i(ev), .dout_o(pin_out), .oe_o(pin_oe),
    .route_o(route), .ien_o(ien), .lvl_o(lvl), .pol_o(pol), .stat_o(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & ien);
  end

  // R10
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(stat != '0));
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ien) == '0) |-> !irq);
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [8];
  logic [31:0] m_s1, m_s2, m_prev, m_rdata;
  bit          m_irq;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_rdata = '0; m_irq = 0;
    end else begin
      logic [31:0] ev;
      logic [31:0] old [8];
      int idx, act;
      for (int i = 0; i < 8; i++) old[i] = m_reg[i];
      old[1] = m_s2;
      ev = '0;
      for (int p = 0; p < 32; p++) begin
        int code;
        bit hit;
        code = {old[6][p], old[5][p]};
        case (code)
          0: hit = !m_s2[p] && m_prev[p];
          1: hit = !m_s2[p];
          2: hit = m_s2[p] && !m_prev[p];
          default: hit = m_s2[p];
        endcase
        ev[p] = hit && old[3][p] && old[4][p];
      end
      idx = int'(bus_addr[10:8]);
      act = int'(bus_addr[3:2]);
      m_irq = (old[7] & old[4]) != 0;
      if (bus_sel && !bus_wr) m_rdata = old[idx];
      m_reg[7] = old[7] | ev;
      if (bus_sel && bus_wr) begin
        if (idx == 7) begin
          if (act == 2) m_reg[7] = (old[7] & ~bus_wdata) | ev;
        end else if (idx != 1) begin
          if (act == 0) m_reg[idx] = bus_wdata;
          else if (act == 1) m_reg[idx] = old[idx] | bus_wdata;
          else if (act == 2) m_reg[idx] = old[idx] & ~bus_wdata;
        end
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 pin_out", pin_out, m_reg[0]);
      chk("R4 pin_oe", pin_oe, m_reg[2]);
      chk("R10 irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R2 bus_rdata", bus_rdata, m_rdata);
    end
  end

  function automatic logic [11:0] ad(input int idx, input int act);
    ad = {1'b0, 3'(idx), 4'h0, 2'(act), 2'b00};
  endfunction

  task automatic wr(input int idx, input int act, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad(idx, act); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, input int act, input logic [31:0] exp_v, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ad(idx, act);
    @(negedge clk);
    bus_sel = 1'b0;
    chk(tag, bus_rdata, exp_v);
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 8; i++) rd(i, 0, 32'h0, "R1 reset reg");

    // R4 / R2 output registers and read at another address
    wr(0, 0, 32'hA5A5_0000);
    wr(2, 0, 32'h0000_FFFF);
    chk("R4 pin_out direct", pin_out, 32'hA5A5_0000);
    chk("R4 pin_oe direct", pin_oe, 32'h0000_FFFF);
    rd(0, 1, 32'hA5A5_0000, "R2 read at set address");

    // R3 write actions
    wr(0, 1, 32'h0000_0001);
    wr(0, 2, 32'hA500_0000);
    rd(0, 0, 32'h00A5_0001, "R3 set then clear");
    wr(0, 3, 32'hFFFF_FFFF);
    rd(0, 2, 32'h00A5_0001, "R3 action 3 ignored");

    // R5 synchronized input, writes ignored
    pins(32'h1234_5678);
    rd(1, 0, 32'h1234_5678, "R5 input data");
    wr(1, 0, 32'h0);
    rd(1, 0, 32'h1234_5678, "R5 input write ignored");
    pins(32'h0);

    // R7 route without enable, then enable without route
    wr(6, 1, 32'h1);
    wr(3, 1, 32'h1);
    pins(32'h1);
    rd(7, 0, 32'h0, "R7 route only");
    pins(32'h0);
    wr(3, 2, 32'h1);
    wr(4, 1, 32'h1);
    pins(32'h1);
    rd(7, 0, 32'h0, "R7 enable only");
    pins(32'h0);

    // R6 rising edge, R9 sticky, R8 acknowledge
    wr(3, 1, 32'h1);
    pins(32'h1);
    rd(7, 0, 32'h1, "R6 rising edge");
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    pins(32'h0);
    rd(7, 0, 32'h1, "R9 edge status sticky");
    wr(7, 0, 32'h0);
    rd(7, 0, 32'h1, "R8 load ignored");
    wr(7, 1, 32'hFFFF_FFFF);
    rd(7, 0, 32'h1, "R8 set ignored");
    wr(7, 2, 32'h1);
    rd(7, 0, 32'h0, "R8 clear acknowledges");
    repeat (2) @(negedge clk);
    chk("R10 irq low", {31'b0, irq}, 32'h0);

    // R6 falling edge on pin 1
    pins(32'h2);
    wr(3, 1, 32'h2);
    wr(4, 1, 32'h2);
    pins(32'h0);
    rd(7, 0, 32'h2, "R6 falling edge");
    wr(7, 2, 32'h2);
    rd(7, 0, 32'h0, "R8 clear pin1");

    // R9 high level on pin 2: clear while level present
    wr(5, 1, 32'h4);
    wr(6, 1, 32'h4);
    wr(3, 1, 32'h4);
    wr(4, 1, 32'h4);
    pins(32'h4);
    rd(7, 0, 32'h4, "R6 high level");
    wr(7, 2, 32'h4);
    rd(7, 0, 32'h4, "R9 level sets again after clear");
    pins(32'h0);
    wr(7, 2, 32'h4);
    rd(7, 0, 32'h0, "R9 clear after level gone");

    // R6 low level on pin 3
    pins(32'h8);
    wr(5, 1, 32'h8);
    wr(3, 1, 32'h8);
    wr(4, 1, 32'h8);
    rd(7, 0, 32'h0, "R6 low level inactive");
    pins(32'h0);
    rd(7, 0, 32'h8, "R6 low level");
    pins(32'h8);
    wr(7, 2, 32'h8);
    rd(7, 0, 32'h0, "R8 clear pin3");

    // R7 / R10 masking keeps status
    pins(32'h9);
    chk("R10 irq from pin0", {31'b0, irq}, 32'h1);
    wr(4, 2, 32'h1);
    repeat (2) @(negedge clk);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    rd(7, 0, 32'h1, "R7 mask keeps status");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule